// File: doc/BRIEF.md
# Calibration Sequence Controller

This block is the mode and calibration state machine of a multichannel converter. A host write to the mode port chooses one of four calibrations: a converter zero-scale self-calibration, a converter full-scale self-calibration, a per-channel zero-scale system calibration, or a per-channel full-scale system calibration. The host also names the channel it applies to. The controller runs for that channel's configured conversion time. It then stores the measured value in the matching calibration register, sets every ready flag, pulls the sync line low and goes back to idle.

The measurement arrives as a stub value with a valid strobe. The last value strobed during the run, or the value presented on the final cycle, is the one stored. Host writes to the calibration registers are accepted only while the controller is idle. A write attempted during a run is dropped and sets a sticky error flag. Any mode write during a run aborts that run, and no calibration register changes.

Top module: `calseq_ctrl`

## Requirements
- R1: A mode write with code 1 (converter zero-scale self), 2 (converter full-scale self), 3 (channel zero-scale system) or 4 (channel full-scale system) while idle starts a run. One cycle later `mode_state` shows the code, `cal_chan` shows the channel, `sync_n` is high and all ready flags are clear.
- R2: `mode_state` stays non-idle for exactly T clock cycles, where T is the reload value last written for the selected channel. A reload value of 0 counts as 1.
- R3: On completion the stored measurement goes into the target register. Code 1 writes selector 0 (converter zero), code 2 writes selector 1 (converter full), code 3 writes selector 2 (channel zero of the run's channel), and code 4 writes selector 3 (channel full of that channel).
- R4: On the completion edge, all ready flags are set, `sync_n` goes low, `mode_state` returns to 0 and `tc_pulse` is high for exactly one cycle.
- R5: During a code 2 run, `cal_range` shows range code 1 (2.5 V unipolar), whatever range the channel has. Every other run shows the channel's configured range.
- R6: A host calibration-register write while idle takes effect. A read returns the selected register on `calreg_rd_data` one cycle after the read address is presented.
- R7: A host calibration-register write while a run is active is ignored and sets `wr_err`. Only reset clears `wr_err`.
- R8: A mode write of any code during a run aborts it. The next cycle shows idle, no `tc_pulse` and `sync_n` high, and the target register keeps its old value.
- R9: A mode write of code 0 or 5..7 while idle leaves `mode_state`, `sync_n` and the ready flags unchanged.
- R10: After reset, `mode_state` is 0, ready flags are 0, `sync_n` is 1, `wr_err` and `tc_pulse` are 0, the converter zero register reads 0 and the converter full register reads 0x200000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_en | input | 1 | Mode write strobe |
| mode_wr_code | input | 3 | Mode code written |
| mode_wr_chan | input | CHW | Channel for the calibration |
| setup_wr_en | input | 1 | Channel setup write strobe |
| setup_wr_chan | input | CHW | Channel being configured |
| setup_wr_time | input | TW | Conversion time reload value, in cycles |
| setup_wr_range | input | 2 | Input range code |
| meas_valid | input | 1 | Measurement strobe |
| meas_value | input | DW | Measured value |
| calreg_wr_en | input | 1 | Host calibration-register write strobe |
| calreg_wr_sel | input | 2 | Register selector (0..3, as in R3) |
| calreg_wr_chan | input | CHW | Channel for per-channel registers |
| calreg_wr_data | input | DW | Write data |
| calreg_rd_sel | input | 2 | Read selector |
| calreg_rd_chan | input | CHW | Read channel |
| calreg_rd_data | output | DW | Read data, one cycle latency |
| mode_state | output | 3 | Current mode, 0 when idle |
| cal_chan | output | CHW | Channel of the current or last run |
| cal_range | output | 2 | Range applied during the run |
| rdy_flags | output | NCH | Per-channel ready flags |
| sync_n | output | 1 | Sync line, driven low on completion |
| tc_pulse | output | 1 | One-cycle pulse at completion |
| wr_err | output | 1 | Sticky flag for a rejected calibration-register write |

## Verification
The hardest cases to reach from the ports are the ones where two actions overlap a run. One is a host register write landing mid-run. The other is a mode write that aborts a run after a measurement has already been strobed. The bench makes both happen by timing the extra strobes against a run whose channel has a long reload value. It also places a measurement inside the run before the abort. It then reads the target register back to show that neither the intruding write nor the aborted measurement reached storage. A channel with a reload value of one covers the case where the measurement strobe and completion fall on the same edge.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE    = 3'd0,
    MODE_ZS_SELF = 3'd1,
    MODE_FS_SELF = 3'd2,
    MODE_ZS_SYS  = 3'd3,
    MODE_FS_SYS  = 3'd4
  } cal_mode_e;

  typedef enum logic [1:0] {
    REG_CONV_ZS = 2'd0,
    REG_CONV_FS = 2'd1,
    REG_CH_ZS   = 2'd2,
    REG_CH_FS   = 2'd3
  } cal_reg_e;

  localparam int          RANGE_W       = 2;
  localparam logic [1:0]  RANGE_UNI_2P5 = 2'b01;

  function automatic logic is_cal_code(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

endpackage

// File: rtl/calseq_setup.sv
// Per-channel conversion time and range register file.
module calseq_setup #(
  parameter int              NCH      = 8,
  parameter int              TW       = 16,
  parameter int              CHW      = (NCH > 1) ? $clog2(NCH) : 1,
  parameter logic [TW-1:0]   DEF_TIME = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [CHW-1:0]                 wr_chan,
  input  logic [TW-1:0]                  wr_time,
  input  logic [calseq_pkg::RANGE_W-1:0] wr_range,
  input  logic [CHW-1:0]                 rd_chan,
  output logic [TW-1:0]                  rd_time,
  output logic [calseq_pkg::RANGE_W-1:0] rd_range
);
  logic [TW-1:0]                  time_q  [NCH];
  logic [calseq_pkg::RANGE_W-1:0] range_q [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        time_q[i]  <= DEF_TIME;
        range_q[i] <= '0;
      end
    end else if (wr_en) begin
      time_q[wr_chan]  <= wr_time;
      range_q[wr_chan] <= wr_range;
    end
  end

  assign rd_time  = time_q[rd_chan];
  assign rd_range = range_q[rd_chan];
endmodule

// File: rtl/calseq_timer.sv
// Down counter that sets the run length.
module calseq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          en,
  output logic          expire
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      // A run of T cycles loads T-1; zero is clamped to a single cycle
      cnt_q <= (load_val == '0) ? '0 : load_val - TW'(1);
    end else if (en && (cnt_q != '0)) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/calseq_bank.sv
// Calibration register storage: two converter-wide registers plus
// per-channel zero and full arrays shaped for block RAM inference.
module calseq_bank #(
  parameter int            NCH          = 8,
  parameter int            DW           = 24,
  parameter int            CHW          = (NCH > 1) ? $clog2(NCH) : 1,
  parameter logic [DW-1:0] CONV_FS_INIT = 24'h200000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     wr_sel,
  input  logic [CHW-1:0] wr_chan,
  input  logic [DW-1:0]  wr_data,
  input  logic [1:0]     rd_sel,
  input  logic [CHW-1:0] rd_chan,
  output logic [DW-1:0]  rd_data
);
  import calseq_pkg::*;

  logic [DW-1:0] ch_zs_mem [NCH];
  logic [DW-1:0] ch_fs_mem [NCH];
  logic [DW-1:0] conv_zs_q, conv_fs_q;
  logic [DW-1:0] zs_rd_q, fs_rd_q, conv_rd_q;
  logic [1:0]    sel_q;

  always_ff @(posedge clk) begin
    if (wr_en && (wr_sel == REG_CH_ZS)) ch_zs_mem[wr_chan] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && (wr_sel == REG_CH_FS)) ch_fs_mem[wr_chan] <= wr_data;
  end

  always_ff @(posedge clk) begin
    zs_rd_q <= ch_zs_mem[rd_chan];
    fs_rd_q <= ch_fs_mem[rd_chan];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_zs_q <= '0;
      conv_fs_q <= CONV_FS_INIT;
    end else if (wr_en) begin
      if (wr_sel == REG_CONV_ZS) conv_zs_q <= wr_data;
      if (wr_sel == REG_CONV_FS) conv_fs_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      conv_rd_q <= '0;
    end else begin
      sel_q     <= rd_sel;
      conv_rd_q <= (rd_sel == REG_CONV_FS) ? conv_fs_q : conv_zs_q;
    end
  end

  always_comb begin
    case (sel_q)
      REG_CH_ZS: rd_data = zs_rd_q;
      REG_CH_FS: rd_data = fs_rd_q;
      default:   rd_data = conv_rd_q;
    endcase
  end
endmodule

// File: rtl/calseq_ctrl.sv
// Calibration mode controller: start, timed run, store, complete or abort.
module calseq_ctrl #(
  parameter int            NCH          = 8,
  parameter int            DW           = 24,
  parameter int            TW           = 16,
  parameter int            CHW          = (NCH > 1) ? $clog2(NCH) : 1,
  parameter logic [TW-1:0] DEF_TIME     = 64,
  parameter logic [DW-1:0] CONV_FS_INIT = 24'h200000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_wr_en,
  input  logic [2:0]     mode_wr_code,
  input  logic [CHW-1:0] mode_wr_chan,
  input  logic           setup_wr_en,
  input  logic [CHW-1:0] setup_wr_chan,
  input  logic [TW-1:0]  setup_wr_time,
  input  logic [1:0]     setup_wr_range,
  input  logic           meas_valid,
  input  logic [DW-1:0]  meas_value,
  input  logic           calreg_wr_en,
  input  logic [1:0]     calreg_wr_sel,
  input  logic [CHW-1:0] calreg_wr_chan,
  input  logic [DW-1:0]  calreg_wr_data,
  input  logic [1:0]     calreg_rd_sel,
  input  logic [CHW-1:0] calreg_rd_chan,
  output logic [DW-1:0]  calreg_rd_data,
  output logic [2:0]     mode_state,
  output logic [CHW-1:0] cal_chan,
  output logic [1:0]     cal_range,
  output logic [NCH-1:0] rdy_flags,
  output logic           sync_n,
  output logic           tc_pulse,
  output logic           wr_err
);
  import calseq_pkg::*;

  cal_mode_e      mode_q;
  logic [CHW-1:0] chan_q;
  logic [DW-1:0]  hold_q;
  logic [NCH-1:0] rdy_q;
  logic           sync_q, err_q, tc_q;
  logic [1:0]     range_q;

  logic [TW-1:0]  sel_time;
  logic [1:0]     sel_range;
  logic           expire;
  logic           in_cal, start, abort, finish, host_ok, host_bad;
  cal_reg_e       tgt_reg;
  logic           bank_we;
  logic [1:0]     bank_sel;
  logic [CHW-1:0] bank_chan;
  logic [DW-1:0]  bank_data;

  calseq_setup #(.NCH(NCH), .TW(TW), .CHW(CHW), .DEF_TIME(DEF_TIME)) u_setup (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (setup_wr_en),
    .wr_chan  (setup_wr_chan),
    .wr_time  (setup_wr_time),
    .wr_range (setup_wr_range),
    .rd_chan  (mode_wr_chan),
    .rd_time  (sel_time),
    .rd_range (sel_range)
  );

  calseq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_val (sel_time),
    .en       (in_cal),
    .expire   (expire)
  );

  // Control decode: a mode write always wins over completion
  assign in_cal   = (mode_q != MODE_IDLE);
  assign start    = mode_wr_en && !in_cal && is_cal_code(mode_wr_code);
  assign abort    = mode_wr_en && in_cal;
  assign finish   = in_cal && !mode_wr_en && expire;
  assign host_ok  = calreg_wr_en && !in_cal;
  assign host_bad = calreg_wr_en && in_cal;

  always_comb begin
    case (mode_q)
      MODE_ZS_SELF: tgt_reg = REG_CONV_ZS;
      MODE_FS_SELF: tgt_reg = REG_CONV_FS;
      MODE_ZS_SYS:  tgt_reg = REG_CH_ZS;
      default:      tgt_reg = REG_CH_FS;
    endcase
  end

  // Single bank write port; the two sources never overlap because the
  // host path is closed whenever a run can complete
  assign bank_we   = host_ok || finish;
  assign bank_sel  = finish ? tgt_reg : calreg_wr_sel;
  assign bank_chan = finish ? chan_q  : calreg_wr_chan;
  assign bank_data = finish ? (meas_valid ? meas_value : hold_q) : calreg_wr_data;

  calseq_bank #(.NCH(NCH), .DW(DW), .CHW(CHW), .CONV_FS_INIT(CONV_FS_INIT)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bank_we),
    .wr_sel  (bank_sel),
    .wr_chan (bank_chan),
    .wr_data (bank_data),
    .rd_sel  (calreg_rd_sel),
    .rd_chan (calreg_rd_chan),
    .rd_data (calreg_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_IDLE;
      chan_q  <= '0;
      hold_q  <= '0;
      rdy_q   <= '0;
      sync_q  <= 1'b1;
      err_q   <= 1'b0;
      tc_q    <= 1'b0;
      range_q <= '0;
    end else begin
      tc_q <= finish;
      if (host_bad) err_q <= 1'b1;
      if (start) begin
        mode_q  <= cal_mode_e'(mode_wr_code);
        chan_q  <= mode_wr_chan;
        hold_q  <= '0;
        rdy_q   <= '0;
        sync_q  <= 1'b1;
        range_q <= (mode_wr_code == MODE_FS_SELF) ? RANGE_UNI_2P5 : sel_range;
      end else if (abort) begin
        mode_q <= MODE_IDLE;
      end else if (finish) begin
        mode_q <= MODE_IDLE;
        rdy_q  <= '1;
        sync_q <= 1'b0;
      end else if (in_cal && meas_valid) begin
        hold_q <= meas_value;
      end
    end
  end

  assign mode_state = mode_q;
  assign cal_chan   = chan_q;
  assign cal_range  = range_q;
  assign rdy_flags  = rdy_q;
  assign sync_n     = sync_q;
  assign tc_pulse   = tc_q;
  assign wr_err     = err_q;
endmodule

// File: rtl/calseq_ctrl_chk.sv
module calseq_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           mode_wr_en,
  input logic [2:0]     mode_wr_code,
  input logic           calreg_wr_en,
  input logic [2:0]     mode_state,
  input logic [1:0]     cal_range,
  input logic [NCH-1:0] rdy_flags,
  input logic           sync_n,
  input logic           tc_pulse,
  input logic           wr_err
);
  logic idle_now, cal_code;
  assign idle_now = (mode_state == 3'd0);
  assign cal_code = (mode_wr_code >= 3'd1) && (mode_wr_code <= 3'd4);

  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_wr_en && idle_now && cal_code) |=>
      ((mode_state == $past(mode_wr_code)) && sync_n && (rdy_flags == '0)));

  assert_done_flags_R4: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> (idle_now && !sync_n && (&rdy_flags)));

  assert_tc_single_R4: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);

  assert_fs_range_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_state == 3'd2) |-> (cal_range == 2'b01));

  assert_wr_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (calreg_wr_en && !idle_now) |=> wr_err);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err);

  assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_wr_en && !idle_now) |=> (idle_now && !tc_pulse && sync_n));

  assert_noop_code_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_wr_en && idle_now && !cal_code) |=>
      (idle_now && $stable(sync_n) && $stable(rdy_flags)));
endmodule

bind calseq_ctrl calseq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode_wr_en   (mode_wr_en),
  .mode_wr_code (mode_wr_code),
  .calreg_wr_en (calreg_wr_en),
  .mode_state   (mode_state),
  .cal_range    (cal_range),
  .rdy_flags    (rdy_flags),
  .sync_n       (sync_n),
  .tc_pulse     (tc_pulse),
  .wr_err       (wr_err)
);

// File: tb/test_calseq_ctrl.sv
module test_calseq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr_en = 0;
  logic [2:0]  mode_wr_code = 0;
  logic [2:0]  mode_wr_chan = 0;
  logic        setup_wr_en = 0;
  logic [2:0]  setup_wr_chan = 0;
  logic [15:0] setup_wr_time = 0;
  logic [1:0]  setup_wr_range = 0;
  logic        meas_valid = 0;
  logic [23:0] meas_value = 0;
  logic        calreg_wr_en = 0;
  logic [1:0]  calreg_wr_sel = 0;
  logic [2:0]  calreg_wr_chan = 0;
  logic [23:0] calreg_wr_data = 0;
  logic [1:0]  calreg_rd_sel = 0;
  logic [2:0]  calreg_rd_chan = 0;
  logic [23:0] calreg_rd_data;
  logic [2:0]  mode_state;
  logic [2:0]  cal_chan;
  logic [1:0]  cal_range;
  logic [7:0]  rdy_flags;
  logic        sync_n, tc_pulse, wr_err;

  calseq_ctrl i_calseq_ctrl (
    .clk(clk), .rst(rst),
    .mode_wr_en(mode_wr_en), .mode_wr_code(mode_wr_code), .mode_wr_chan(mode_wr_chan),
    .setup_wr_en(setup_wr_en), .setup_wr_chan(setup_wr_chan),
    .setup_wr_time(setup_wr_time), .setup_wr_range(setup_wr_range),
    .meas_valid(meas_valid), .meas_value(meas_value),
    .calreg_wr_en(calreg_wr_en), .calreg_wr_sel(calreg_wr_sel),
    .calreg_wr_chan(calreg_wr_chan), .calreg_wr_data(calreg_wr_data),
    .calreg_rd_sel(calreg_rd_sel), .calreg_rd_chan(calreg_rd_chan),
    .calreg_rd_data(calreg_rd_data),
    .mode_state(mode_state), .cal_chan(cal_chan), .cal_range(cal_range),
    .rdy_flags(rdy_flags), .sync_n(sync_n), .tc_pulse(tc_pulse), .wr_err(wr_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [23:0] exp;
    string       req;
    int          due;
  } rd_item_t;
  rd_item_t sbq[$];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each queued readback in its due cycle
  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      rd_item_t it;
      it = sbq.pop_front();
      chk(calreg_rd_data, it.exp, it.req, "readback");
    end
  end

  // Driver: present a read address and queue the expected data
  task automatic exp_reg(input logic [1:0] sel, input logic [2:0] ch,
                         input logic [23:0] val, input string req);
    @(negedge clk);
    calreg_rd_sel  = sel;
    calreg_rd_chan = ch;
    sbq.push_back('{exp: val, req: req, due: cyc + 1});
  endtask

  task automatic setup(input logic [2:0] ch, input logic [15:0] t, input logic [1:0] r);
    @(negedge clk);
    setup_wr_en = 1; setup_wr_chan = ch; setup_wr_time = t; setup_wr_range = r;
    @(negedge clk);
    setup_wr_en = 0;
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [2:0] ch, input logic [23:0] d);
    @(negedge clk);
    calreg_wr_en = 1; calreg_wr_sel = sel; calreg_wr_chan = ch; calreg_wr_data = d;
    @(negedge clk);
    calreg_wr_en = 0;
  endtask

  task automatic run_cal(input logic [2:0] code, input logic [2:0] ch, input int tlen,
                         input logic [23:0] val, input logic [1:0] exp_rng,
                         input bit intrude);
    int n;
    @(negedge clk);
    mode_wr_en = 1; mode_wr_code = code; mode_wr_chan = ch;
    @(negedge clk);
    mode_wr_en = 0;
    chk(mode_state, code, "R1", "mode after start");
    chk(sync_n, 1, "R1", "sync after start");
    chk(rdy_flags, 0, "R1", "ready cleared");
    chk(cal_chan, ch, "R1", "channel");
    chk(cal_range, exp_rng, "R5", "range");
    meas_valid = 1; meas_value = val;
    if (intrude) begin
      calreg_wr_en = 1; calreg_wr_sel = 2'd3; calreg_wr_chan = ch; calreg_wr_data = 24'h555555;
    end
    n = 1;
    @(negedge clk);
    meas_valid = 0; meas_value = ~val; calreg_wr_en = 0;
    if (intrude) chk(wr_err, 1, "R7", "error flag");
    while (mode_state != 3'd0 && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk(n, tlen, "R2", "run length");
    chk(tc_pulse, 1, "R4", "tc pulse");
    chk(sync_n, 0, "R4", "sync low");
    chk(rdy_flags, 8'hFF, "R4", "all ready");
    @(negedge clk);
    chk(tc_pulse, 0, "R4", "tc single cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(mode_state, 0, "R10", "mode");
    chk(rdy_flags, 0, "R10", "ready");
    chk(sync_n, 1, "R10", "sync");
    chk(wr_err, 0, "R10", "error");
    chk(tc_pulse, 0, "R10", "tc");
    exp_reg(2'd0, 3'd0, 24'h000000, "R10");
    exp_reg(2'd1, 3'd0, 24'h200000, "R10");

    setup(3'd2, 16'd5, 2'd2);
    setup(3'd5, 16'd1, 2'd0);
    setup(3'd7, 16'd12, 2'd3);
    setup(3'd4, 16'd8, 2'd2);
    setup(3'd6, 16'd0, 2'd1);

    // R9 no-op code while idle after reset
    @(negedge clk); mode_wr_en = 1; mode_wr_code = 3'd6; mode_wr_chan = 3'd2;
    @(negedge clk); mode_wr_en = 0;
    chk(mode_state, 0, "R9", "mode after code 6");
    chk(sync_n, 1, "R9", "sync after code 6");

    // R1..R5 channel zero-scale system run, T=5
    run_cal(3'd3, 3'd2, 5, 24'h123456, 2'd2, 1'b0);
    exp_reg(2'd2, 3'd2, 24'h123456, "R3");

    // R9 code 0 and code 5 after completion: flags stay
    @(negedge clk); mode_wr_en = 1; mode_wr_code = 3'd0;
    @(negedge clk); mode_wr_code = 3'd5;
    @(negedge clk); mode_wr_en = 0;
    chk(mode_state, 0, "R9", "mode");
    chk(sync_n, 0, "R9", "sync held low");
    chk(rdy_flags, 8'hFF, "R9", "ready held");

    // R5 converter full-scale self run forces range 1, T=12
    run_cal(3'd2, 3'd7, 12, 24'h1FF00A, 2'd1, 1'b0);
    exp_reg(2'd1, 3'd0, 24'h1FF00A, "R3");

    // Single-cycle run: measurement and completion on the same edge
    run_cal(3'd1, 3'd5, 1, 24'h000321, 2'd0, 1'b0);
    exp_reg(2'd0, 3'd0, 24'h000321, "R3");

    // Reload value zero counts as one
    run_cal(3'd4, 3'd6, 1, 24'hC0FFEE, 2'd1, 1'b0);
    exp_reg(2'd3, 3'd6, 24'hC0FFEE, "R2");

    run_cal(3'd4, 3'd2, 5, 24'h2A0B0C, 2'd2, 1'b0);
    exp_reg(2'd3, 3'd2, 24'h2A0B0C, "R3");
    exp_reg(2'd2, 3'd2, 24'h123456, "R3");

    // R6 host write while idle
    host_wr(2'd2, 3'd3, 24'hABCDEF);
    exp_reg(2'd2, 3'd3, 24'hABCDEF, "R6");
    host_wr(2'd0, 3'd0, 24'h00F00D);
    exp_reg(2'd0, 3'd0, 24'h00F00D, "R6");

    // R7 host write during a run is dropped
    host_wr(2'd3, 3'd7, 24'h0F0F0F);
    run_cal(3'd3, 3'd7, 12, 24'h0A0A0A, 2'd3, 1'b1);
    exp_reg(2'd3, 3'd7, 24'h0F0F0F, "R7");
    exp_reg(2'd2, 3'd7, 24'h0A0A0A, "R3");

    // R8 abort after a measurement was strobed
    host_wr(2'd2, 3'd4, 24'h111111);
    @(negedge clk); mode_wr_en = 1; mode_wr_code = 3'd3; mode_wr_chan = 3'd4;
    @(negedge clk); mode_wr_en = 0; meas_valid = 1; meas_value = 24'h777777;
    chk(rdy_flags, 0, "R8", "ready cleared by start");
    @(negedge clk); meas_valid = 0;
    @(negedge clk); mode_wr_en = 1; mode_wr_code = 3'd0;
    @(negedge clk); mode_wr_en = 0;
    chk(mode_state, 0, "R8", "idle after abort");
    chk(tc_pulse, 0, "R8", "no tc on abort");
    chk(sync_n, 1, "R8", "sync stays high");
    chk(rdy_flags, 0, "R8", "ready not set");
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (tc_pulse !== 1'b0) chk(tc_pulse, 0, "R8", "late tc");
    end
    exp_reg(2'd2, 3'd4, 24'h111111, "R8");
    chk(wr_err, 1, "R7", "error still sticky");

    repeat (4) @(negedge clk);
    chk(sbq.size(), 0, "R6", "scoreboard drained");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule